// File: doc/BRIEF.md
# Two-Stage Programmable Crosspoint Switch

This block is a non-blocking crosspoint switch with 34 inputs and 34 outputs. Each output has its own selector that can pick any input, so one input may drive a single output, several outputs or all of them at once. The data path from input to output has no registers. A change on an input reaches every output that selects it in the same cycle.

Each output's selection is held in two register stages. A pending stage collects new assignments while the load strobe is high. An active stage drives the selector and changes only when the global apply strobe is high. On the clock edge where apply is high, every active entry takes the pending value at the same moment. Software can therefore build a whole new routing over several load cycles and switch to it in one step. Outputs whose selection stays the same carry data without a break.

Each load is decoded in one of four ways. The two mode bits choose between a single-port write and a mask write, and between a source taken from the input-address bus and a pass-through source (output N takes input N).

Top module: `xbar_switch`

## Requirements
- R1: After reset, both stages hold pass-through, so each output N carries input N.
- R2: `modeSel` bit 0 = 0 selects a single-port write. On a clock edge with `loadStrobe` high, only the pending entry indexed by `outAddr[5:0]` is written. With `modeSel` = 2'b00, that entry takes the source `inAddr`.
- R3: `modeSel` bit 0 = 1 selects a mask write. On a load edge, every pending entry whose `outAddr` bit is set is written. With `modeSel` = 2'b01, each of those entries takes the source `inAddr`.
- R4: `modeSel` bit 1 = 1 selects the pass-through source. `inAddr` is ignored, including values of 34 or more, and each written entry N takes input N. This applies to both 2'b10 (single-port) and 2'b11 (mask).
- R5: Writing pending entries, or holding the load strobe high over several edges, never changes the active selection or the outputs while `cfgStrobe` is low.
- R6: On a clock edge with `cfgStrobe` high, all 34 active entries take their pending values together. The active entries then hold once `cfgStrobe` falls.
- R7: When `cfgStrobe` is high on the same edge as a load, or is held high, the assignment loaded at that edge drives the outputs from that edge onward.
- R8: A load is ignored, and no pending entry changes, in two cases. The first is a single-port write with `outAddr[5:0]` of 34 or more. The second is a write with a user-defined source and `inAddr` of 34 or more.
- R9: Outputs whose active selection is unchanged by an apply keep following their input in every cycle, including the apply cycle.
- R10: One input may be routed to all 34 outputs at once (broadcast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Bit 0: 1 = mask write. Bit 1: 1 = pass-through source |
| loadStrobe | input | 1 | Writes the pending stage on each edge it is high |
| cfgStrobe | input | 1 | Copies the pending stage into the active stage on each edge it is high |
| inAddr | input | 6 | Source input index for user-defined modes |
| outAddr | input | 34 | Output mask, or output index in bits 5:0 |
| dataIn | input | 34 | One data bit per input port |
| dataOut | output | 34 | One data bit per output port |

## Verification
A load reaches the pending stage at the edge where it is sampled. An apply reaches the outputs just after its own edge, so a load and an apply on the same edge show up after that single edge. The data path itself adds no delay, so an output reflects `dataIn` within the same cycle. The bench updates a behavioural model at each rising edge from the inputs held steady since the previous falling edge. At the falling edge it then drives fresh random data and compares all 34 outputs, so each result is checked in the first cycle it is due and in every cycle it must persist.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Decoding of the two mode bits: bit 0 = mask write, bit 1 = pass-through source
  typedef enum logic [1:0] {
    MODE_SINGLE_USER = 2'b00,
    MODE_MASK_USER   = 2'b01,
    MODE_SINGLE_PASS = 2'b10,
    MODE_MASK_PASS   = 2'b11
  } xbar_mode_e;

  // Strobes handed from the control decode to the datapath
  typedef struct packed {
    logic usePass;   // written entries take their own index as source
    logic applyAll;  // copy the pending stage into the active stage
  } xbar_strobe_t;

endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 34,
  parameter int SEL_W     = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 loadStrobe,
  input  logic                 cfgStrobe,
  input  logic [SEL_W-1:0]     inAddr,
  input  logic [NUM_PORTS-1:0] outAddr,
  output logic [NUM_PORTS-1:0] writeEn,
  output logic [SEL_W-1:0]     userSrc,
  output xbar_strobe_t         strobes
);

  localparam logic [SEL_W:0] PORT_LIMIT = (SEL_W+1)'(NUM_PORTS);

  xbar_mode_e modeNow;
  logic       maskMode;
  logic       passMode;
  logic [SEL_W-1:0] singleIdx;
  logic       singleOk;
  logic       sourceOk;

  always_comb begin
    modeNow   = xbar_mode_e'(modeSel);
    maskMode  = (modeNow == MODE_MASK_USER) || (modeNow == MODE_MASK_PASS);
    passMode  = (modeNow == MODE_SINGLE_PASS) || (modeNow == MODE_MASK_PASS);
    singleIdx = outAddr[SEL_W-1:0];
    singleOk  = {1'b0, singleIdx} < PORT_LIMIT;
    sourceOk  = passMode || ({1'b0, inAddr} < PORT_LIMIT);
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_wen
    always_comb begin
      if (!loadStrobe || !sourceOk)
        writeEn[o] = 1'b0;
      else if (maskMode)
        writeEn[o] = outAddr[o];
      else
        writeEn[o] = singleOk && (singleIdx == SEL_W'(o));
    end
  end

  assign userSrc          = inAddr;
  assign strobes.usePass  = passMode;
  assign strobes.applyAll = cfgStrobe;

  // R2: a single-port load touches at most one entry
  assert_single_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[0] |-> $onehot0(writeEn));

  // R8: out-of-range addresses write nothing
  assert_bad_addr_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((!modeSel[1] && {1'b0, inAddr} >= PORT_LIMIT) ||
     (!modeSel[0] && {1'b0, outAddr[SEL_W-1:0]} >= PORT_LIMIT)) |-> (writeEn == '0));

  // R5: no write without the load strobe
  assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |-> (writeEn == '0));

endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 34,
  parameter int DATA_W    = 1,
  parameter int SEL_W     = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        writeEn,
  input  logic [SEL_W-1:0]            userSrc,
  input  xbar_strobe_t                strobes,
  input  logic [NUM_PORTS*DATA_W-1:0] dataIn,
  output logic [NUM_PORTS*DATA_W-1:0] dataOut
);

  logic [NUM_PORTS-1:0][SEL_W-1:0] pendSel;
  logic [NUM_PORTS-1:0][SEL_W-1:0] pendNext;
  logic [NUM_PORTS-1:0][SEL_W-1:0] activeSel;

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_pend
    always_comb begin
      if (!writeEn[o])
        pendNext[o] = pendSel[o];
      else if (strobes.usePass)
        pendNext[o] = SEL_W'(o);
      else
        pendNext[o] = userSrc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        pendSel[o]   <= SEL_W'(o);
        activeSel[o] <= SEL_W'(o);
      end
    end else begin
      pendSel <= pendNext;
      if (strobes.applyAll)
        activeSel <= pendNext;
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_mux
    always_comb begin
      dataOut[o*DATA_W +: DATA_W] = '0;
      for (int j = 0; j < NUM_PORTS; j++) begin
        if (activeSel[o] == SEL_W'(j))
          dataOut[o*DATA_W +: DATA_W] = dataIn[j*DATA_W +: DATA_W];
      end
    end

    // R4: a pass-through write leaves the entry pointing at its own input
    assert_pass_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
      (writeEn[o] && strobes.usePass) |=> (pendSel[o] == SEL_W'(o)));
  end

  // R5: the active stage holds while apply is low
  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.applyAll |=> $stable(activeSel));

  // R6 / R7: after an apply both stages agree
  assert_apply_copies_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.applyAll |=> (activeSel == pendSel));

  // R8: without any write enable the pending stage holds
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn == '0) |=> $stable(pendSel));

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int NUM_PORTS = 34,
  parameter int DATA_W    = 1,
  parameter int ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  modeSel,
  input  logic                        loadStrobe,
  input  logic                        cfgStrobe,
  input  logic [ADDR_W-1:0]           inAddr,
  input  logic [NUM_PORTS-1:0]        outAddr,
  input  logic [NUM_PORTS*DATA_W-1:0] dataIn,
  output logic [NUM_PORTS*DATA_W-1:0] dataOut
);

  logic [NUM_PORTS-1:0] writeEn;
  logic [ADDR_W-1:0]    userSrc;
  xbar_strobe_t         strobes;

  xbar_ctrl #(.NUM_PORTS(NUM_PORTS), .SEL_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .loadStrobe(loadStrobe),
    .cfgStrobe(cfgStrobe), .inAddr(inAddr), .outAddr(outAddr),
    .writeEn(writeEn), .userSrc(userSrc), .strobes(strobes)
  );

  xbar_datapath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .SEL_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .userSrc(userSrc),
    .strobes(strobes), .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: tb/test_xbar_switch.sv
`timescale 1ns/100ps
module test_xbar_switch;

  localparam int NP = 34;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic          loadStrobe = 1'b0;
  logic          cfgStrobe = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic [NP-1:0] outAddr = '0;
  logic [NP-1:0] dataIn = '0;
  logic [NP-1:0] dataOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int pendRef [NP];
  int actRef  [NP];

  always #2.5 clk = ~clk;

  xbar_switch i_xbar_switch (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .loadStrobe(loadStrobe),
    .cfgStrobe(cfgStrobe), .inAddr(inAddr), .outAddr(outAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  // Behavioural model: one update per rising edge
  task automatic modelEdge();
    int nxt [NP];
    int oi;
    if (!rstN) begin
      for (int i = 0; i < NP; i++) begin pendRef[i] = i; actRef[i] = i; end
      return;
    end
    nxt = pendRef;
    if (loadStrobe && (modeSel[1] || int'(inAddr) < NP)) begin
      if (modeSel[0]) begin
        for (int i = 0; i < NP; i++)
          if (outAddr[i]) nxt[i] = modeSel[1] ? i : int'(inAddr);
      end else begin
        oi = int'(outAddr[AW-1:0]);
        if (oi < NP) nxt[oi] = modeSel[1] ? oi : int'(inAddr);
      end
    end
    pendRef = nxt;
    if (cfgStrobe) actRef = nxt;
  endtask

  task automatic tick(input string tag);
    logic [NP-1:0] expv;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    dataIn = {$urandom, $urandom};
    #1;
    for (int i = 0; i < NP; i++) expv[i] = dataIn[actRef[i]];
    checks++;
    if (dataOut !== expv) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected=%h", tag, dataOut, expv);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic ld, input logic cf,
                       input int ia, input logic [NP-1:0] oa);
    modeSel = m; loadStrobe = ld; cfgStrobe = cf;
    inAddr = AW'(ia); outAddr = oa;
  endtask

  task automatic idle();
    drive(2'b00, 1'b0, 1'b0, 0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state is pass-through
    tick("R1");
    tick("R1");
    rstN = 1'b1;
    tick("R1");
    tick("R1");

    // R2 / R5: single-port user writes, not yet applied
    drive(2'b00, 1'b1, 1'b0, 5, NP'(0));   tick("R5");
    drive(2'b00, 1'b1, 1'b0, 9, NP'(33));  tick("R5");
    drive(2'b00, 1'b1, 1'b0, 7, NP'(12));  tick("R5");
    idle(); tick("R5"); tick("R5");
    // R6: apply all together, then hold
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R6");
    idle(); tick("R6"); tick("R2"); tick("R6");

    // R3: mask write, input 1 to outputs 1, 2, 5
    drive(2'b01, 1'b1, 1'b0, 1, NP'(34'b100110)); tick("R3");
    idle(); tick("R5");
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R3");
    idle(); tick("R3");

    // R4: pass-through in both shapes, inAddr ignored even when out of range
    drive(2'b10, 1'b1, 1'b0, 60, NP'(0));  tick("R4");
    drive(2'b11, 1'b1, 1'b0, 63, NP'(34'b100110)); tick("R4");
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R4");
    idle(); tick("R4");

    // R8: out-of-range addresses write nothing
    drive(2'b00, 1'b1, 1'b0, 3, NP'(40));  tick("R8");
    drive(2'b10, 1'b1, 1'b0, 3, NP'(63));  tick("R8");
    drive(2'b00, 1'b1, 1'b0, 34, NP'(4));  tick("R8");
    drive(2'b01, 1'b1, 1'b0, 50, {NP{1'b1}}); tick("R8");
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R8");
    idle(); tick("R8");

    // R7: load and apply on the same edge, then apply held high
    drive(2'b00, 1'b1, 1'b1, 20, NP'(3)); tick("R7");
    drive(2'b01, 1'b1, 1'b1, 8, NP'(34'hF0)); tick("R7");
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R7");
    drive(2'b10, 1'b1, 1'b1, 0, NP'(3)); tick("R7");
    idle(); tick("R7");

    // R10: broadcast input 33 to every output
    drive(2'b01, 1'b1, 1'b0, 33, {NP{1'b1}}); tick("R10");
    drive(2'b00, 1'b0, 1'b1, 0, '0); tick("R10");
    idle(); tick("R10");
    // back to pass-through via mask pass mode, applied together
    drive(2'b11, 1'b1, 1'b1, 0, {NP{1'b1}}); tick("R10");
    idle(); tick("R1");

    // R9: random mix, every output compared on every cycle
    for (int n = 0; n < 400; n++) begin
      drive(2'($urandom), ($urandom % 3) == 0, ($urandom % 5) == 0,
            int'($urandom % 40), {$urandom, $urandom});
      tick("R9");
    end
    idle(); tick("R9");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule